// File: doc/BRIEF.md
# ASID-Tagged Set-Associative Address Translator

This block translates a 32-bit virtual address through a small set-associative translation buffer. Every way holds a few entries, each with a virtual page number, a physical page number, a 4-bit attribute code and an 8-bit address-space tag. The set is picked by the low bits of the virtual page number, and all ways are compared in parallel. A tag only counts as present when it appears in one of the four byte slots of a packed ring-mapping word. The slot index is the privilege ring of the entry.

A lookup returns its result on the clock edge after it is requested. The result holds the physical address, the read, write and execute rights, a cache policy and a fault cause. The page-table-entry address is produced on every lookup, so that an external walker can fetch the entry after a miss. That walker returns the fetched entry through the refill port, and the block writes it into a way picked round-robin.

Top module: `asid_tlb_xlate`

## Requirements
- R1: The ring-mapping word resets to 0x04030201 and is replaced by `ring_wdata` when `ring_we` is high. The ring of an entry is the lowest byte index (byte i = bits 8i+7:8i) whose value equals the entry's tag. A tag found in no byte never hits.
- R2: An entry hits only when its stored page number equals `lk_va[31:12]` and its tag is nonzero. After reset every tag is zero, so every lookup misses. The set index is `va[13:12]`.
- R3: Exactly one hit is needed. Zero hits give a miss cause: 1 on the fetch side, 5 on the data side. Two or more hits give a multi-hit cause: 2 on the fetch side, 6 on the data side. `lk_kind` is 0 for load, 1 for store, 2 for fetch, and 3 is treated as a load.
- R4: When the hit entry's ring is numerically lower than `lk_ring`, the block reports a privilege fault: cause 3 for a fetch, 7 for a load or store.
- R5: An attribute value below 12 grants read. It grants execute when bit 0 is set and write when bit 1 is set. Bits 3:2 give the cache policy (0 bypass, 1 write-back, 2 write-through), and `res_cache` uses the same codes.
- R6: Attribute 13 grants read and write with cache policy 3 (isolate). Attributes 12, 14 and 15 grant nothing and report cache 0.
- R7: A fetch loses its read and write rights, and a load or store loses its execute right. A right that is missing gives cause 4 (fetch prohibited), 8 (load prohibited) or 9 (store prohibited).
- R8: With cause 0, `res_pa` is the entry's physical page number in bits 31:12 with `va[11:0]` below it. With any other cause, `res_pa` and all rights are zero.
- R9: `res_pte_addr` is (`pt_base` OR (va >> 10)) with bits 1:0 cleared, for every lookup.
- R10: The refill PTE carries the physical page in bits 31:12, the ring in bits 5:4 and the attribute in bits 3:0. The stored tag is the ring-mapping byte that the ring selects. The refill way comes from a 2-bit counter that resets to 0 and is incremented before each use, so the first refill goes to way 1. `fill_way_next` shows the way the next refill will use.
- R11: `res_valid` is high exactly one cycle after `lk_en`, and the result reflects the buffer as it stood before any refill in the same cycle. Cause priority is miss or multi-hit first, then privilege, then rights.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_en | input | 1 | Start a lookup this cycle |
| lk_va | input | 32 | Virtual address to translate |
| lk_kind | input | 2 | Access type: 0 load, 1 store, 2 fetch, 3 load |
| lk_ring | input | 2 | Current privilege ring |
| pt_base | input | 32 | Page-table base address |
| ring_we | input | 1 | Write the ring-mapping word |
| ring_wdata | input | 32 | New ring-mapping word |
| fill_en | input | 1 | Refill one entry |
| fill_va | input | 32 | Virtual address being refilled |
| fill_pte | input | 32 | Fetched page-table entry |
| res_valid | output | 1 | Result valid |
| res_pa | output | 32 | Physical address |
| res_rd | output | 1 | Read granted |
| res_wr | output | 1 | Write granted |
| res_ex | output | 1 | Execute granted |
| res_cache | output | 2 | Cache policy code |
| res_cause | output | 4 | Fault cause, 0 if none |
| res_pte_addr | output | 32 | Page-table-entry address |
| fill_way_next | output | 2 | Way the next refill will write |

## Verification
On every cycle, assertions check the following:
- the one-cycle result latency;
- that a fetch never reports read or write rights and a data access never reports execute;
- that a faulting result carries no address and no rights;
- that the page-table-entry address is word-aligned;
- that the refill way advances by one on each refill;
- that the ring-mapping word holds its reset value after reset.

Which cause wins when several faults apply, how tags are matched against the ring word, and the attribute decode can only be shown by the bench's scenarios. Each scenario is compared against a behavioural model of the buffer. Those scenarios cover these cases:
- duplicate entries;
- ring-word rewrites that hide entries;
- a refill and a lookup in the same cycle;
- round-robin wrap.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;

  typedef enum logic [1:0] {
    CACHE_BYPASS = 2'd0,
    CACHE_WB     = 2'd1,
    CACHE_WT     = 2'd2,
    CACHE_ISO    = 2'd3
  } cache_pol_e;

  typedef enum logic [3:0] {
    CAUSE_NONE      = 4'd0,
    CAUSE_I_MISS    = 4'd1,
    CAUSE_I_MULTI   = 4'd2,
    CAUSE_I_PRIV    = 4'd3,
    CAUSE_I_PROHIB  = 4'd4,
    CAUSE_D_MISS    = 4'd5,
    CAUSE_D_MULTI   = 4'd6,
    CAUSE_D_PRIV    = 4'd7,
    CAUSE_LD_PROHIB = 4'd8,
    CAUSE_ST_PROHIB = 4'd9
  } fault_cause_e;

  typedef struct packed {
    logic       rd;
    logic       wr;
    logic       ex;
    cache_pol_e cache;
  } tlb_rights_t;

  // Attribute code to raw rights, before the side mask is applied.
  function automatic tlb_rights_t attr_rights(input logic [3:0] a);
    tlb_rights_t r;
    r = '{rd: 1'b0, wr: 1'b0, ex: 1'b0, cache: CACHE_BYPASS};
    if (a < 4'd12) begin
      r.rd    = 1'b1;
      r.ex    = a[0];
      r.wr    = a[1];
      r.cache = cache_pol_e'(a[3:2]);
    end else if (a == 4'd13) begin
      r.rd    = 1'b1;
      r.wr    = 1'b1;
      r.cache = CACHE_ISO;
    end
    return r;
  endfunction

endpackage

// File: rtl/asid_ring_lookup.sv
module asid_ring_lookup (
  input  logic [31:0] ring_word,
  input  logic [7:0]  asid,
  output logic        found,
  output logic [1:0]  ring
);
  // Lowest matching byte wins: scan downward so that slot 0 is written last.
  always_comb begin
    found = 1'b0;
    ring  = 2'd0;
    for (int i = 3; i >= 0; i--) begin
      if (ring_word[8*i +: 8] == asid) begin
        found = 1'b1;
        ring  = 2'(i);
      end
    end
  end
endmodule

// File: rtl/asid_tlb_way.sv
module asid_tlb_way #(
  parameter int VPN_W = 20,
  parameter int PPN_W = 20,
  parameter int SETS  = 4,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fill_we,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic [7:0]       fill_asid,
  input  logic [3:0]       fill_attr,
  input  logic [VPN_W-1:0] look_vpn,
  input  logic [31:0]      ring_word,
  output logic             hit,
  output logic [1:0]       hit_ring,
  output logic [PPN_W-1:0] hit_ppn,
  output logic [3:0]       hit_attr
);
  logic [VPN_W-1:0] vpn_q  [SETS];
  logic [PPN_W-1:0] ppn_q  [SETS];
  logic [3:0]       attr_q [SETS];
  logic [7:0]       asid_q [SETS];

  logic [SET_W-1:0] fill_set, look_set;
  logic             ring_found;

  assign fill_set = fill_vpn[SET_W-1:0];
  assign look_set = look_vpn[SET_W-1:0];

  // Payload fields carry no reset, so they can sit in plain storage.
  always_ff @(posedge clk) begin
    if (fill_we) begin
      vpn_q[fill_set]  <= fill_vpn;
      ppn_q[fill_set]  <= fill_ppn;
      attr_q[fill_set] <= fill_attr;
    end
  end

  // Only the tag is reset; a zero tag marks an empty entry.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) asid_q[s] <= 8'd0;
    end else if (fill_we) begin
      asid_q[fill_set] <= fill_asid;
    end
  end

  asid_ring_lookup u_ring (
    .ring_word (ring_word),
    .asid      (asid_q[look_set]),
    .found     (ring_found),
    .ring      (hit_ring)
  );

  assign hit      = (vpn_q[look_set] == look_vpn) && (asid_q[look_set] != 8'd0) && ring_found;
  assign hit_ppn  = ppn_q[look_set];
  assign hit_attr = attr_q[look_set];
endmodule

// File: rtl/asid_tlb_xlate.sv
module asid_tlb_xlate
  import asid_tlb_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int SETS      = 4,
  parameter int NUM_WAYS  = 4,
  parameter logic [31:0] RING_RESET = 32'h0403_0201
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            lk_en,
  input  logic [VA_W-1:0] lk_va,
  input  logic [1:0]      lk_kind,
  input  logic [1:0]      lk_ring,
  input  logic [VA_W-1:0] pt_base,
  input  logic            ring_we,
  input  logic [31:0]     ring_wdata,
  input  logic            fill_en,
  input  logic [VA_W-1:0] fill_va,
  input  logic [VA_W-1:0] fill_pte,
  output logic            res_valid,
  output logic [VA_W-1:0] res_pa,
  output logic            res_rd,
  output logic            res_wr,
  output logic            res_ex,
  output logic [1:0]      res_cache,
  output logic [3:0]      res_cause,
  output logic [VA_W-1:0] res_pte_addr,
  output logic [1:0]      fill_way_next
);
  localparam int VPN_W = VA_W - PAGE_BITS;
  localparam int CNT_W = $clog2(NUM_WAYS + 1);

  logic [31:0] ring_q;
  logic [1:0]  rr_q;
  logic [1:0]  fill_way;
  logic [7:0]  fill_asid;

  logic [NUM_WAYS-1:0] hit_vec;
  logic [1:0]          way_ring [NUM_WAYS];
  logic [VPN_W-1:0]    way_ppn  [NUM_WAYS];
  logic [3:0]          way_attr [NUM_WAYS];

  // ring-mapping word and refill pointer
  always_ff @(posedge clk) begin
    if (rst) begin
      ring_q <= RING_RESET;
      rr_q   <= 2'd0;
    end else begin
      if (ring_we) ring_q <= ring_wdata;
      if (fill_en) rr_q   <= rr_q + 2'd1;
    end
  end

  assign fill_way      = rr_q + 2'd1;
  assign fill_way_next = fill_way;
  assign fill_asid     = ring_q[8*fill_pte[5:4] +: 8];

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    asid_tlb_way #(.VPN_W(VPN_W), .PPN_W(VPN_W), .SETS(SETS)) u_way (
      .clk       (clk),
      .rst       (rst),
      .fill_we   (fill_en && (32'(fill_way) == w)),
      .fill_vpn  (fill_va[VA_W-1:PAGE_BITS]),
      .fill_ppn  (fill_pte[VA_W-1:PAGE_BITS]),
      .fill_asid (fill_asid),
      .fill_attr (fill_pte[3:0]),
      .look_vpn  (lk_va[VA_W-1:PAGE_BITS]),
      .ring_word (ring_q),
      .hit       (hit_vec[w]),
      .hit_ring  (way_ring[w]),
      .hit_ppn   (way_ppn[w]),
      .hit_attr  (way_attr[w])
    );
  end

  // combine the ways
  logic [CNT_W-1:0] n_hits;
  logic [VPN_W-1:0] sel_ppn;
  logic [3:0]       sel_attr;
  logic [1:0]       sel_ring;

  always_comb begin
    n_hits   = '0;
    sel_ppn  = '0;
    sel_attr = '0;
    sel_ring = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (hit_vec[w]) begin
        n_hits   = n_hits + 1'b1;
        sel_ppn  = sel_ppn | way_ppn[w];
        sel_attr = sel_attr | way_attr[w];
        sel_ring = sel_ring | way_ring[w];
      end
    end
  end

  // rights, fault priority and address formation
  logic         is_fetch, is_store, granted;
  tlb_rights_t  rights;
  fault_cause_e cause;

  assign is_fetch = (lk_kind == 2'd2);
  assign is_store = (lk_kind == 2'd1);

  always_comb begin
    rights = attr_rights(sel_attr);
    if (is_fetch) begin
      rights.rd = 1'b0;
      rights.wr = 1'b0;
    end else begin
      rights.ex = 1'b0;
    end
    granted = is_fetch ? rights.ex : (is_store ? rights.wr : rights.rd);

    if (n_hits == '0)
      cause = is_fetch ? CAUSE_I_MISS : CAUSE_D_MISS;
    else if (n_hits > 1)
      cause = is_fetch ? CAUSE_I_MULTI : CAUSE_D_MULTI;
    else if (sel_ring < lk_ring)
      cause = is_fetch ? CAUSE_I_PRIV : CAUSE_D_PRIV;
    else if (!granted)
      cause = is_fetch ? CAUSE_I_PROHIB : (is_store ? CAUSE_ST_PROHIB : CAUSE_LD_PROHIB);
    else
      cause = CAUSE_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid    <= 1'b0;
      res_pa       <= '0;
      res_rd       <= 1'b0;
      res_wr       <= 1'b0;
      res_ex       <= 1'b0;
      res_cache    <= 2'd0;
      res_cause    <= 4'd0;
      res_pte_addr <= '0;
    end else begin
      res_valid <= lk_en;
      if (lk_en) begin
        res_cause    <= cause;
        res_pte_addr <= (pt_base | (lk_va >> 10)) & ~VA_W'(3);
        if (cause == CAUSE_NONE) begin
          res_pa    <= {sel_ppn, lk_va[PAGE_BITS-1:0]};
          res_rd    <= rights.rd;
          res_wr    <= rights.wr;
          res_ex    <= rights.ex;
          res_cache <= rights.cache;
        end else begin
          res_pa    <= '0;
          res_rd    <= 1'b0;
          res_wr    <= 1'b0;
          res_ex    <= 1'b0;
          res_cache <= 2'd0;
        end
      end
    end
  end

  // Assertions

  p_ring_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> ring_q == RING_RESET);

  p_result_latency_r11: assert property (@(posedge clk) disable iff (rst)
    lk_en |=> res_valid);

  p_no_stray_result_r11: assert property (@(posedge clk) disable iff (rst)
    !lk_en |=> !res_valid);

  p_side_mask_r7: assert property (@(posedge clk) disable iff (rst)
    (lk_en && lk_kind == 2'd2) |=> (!res_rd && !res_wr));

  p_data_no_exec_r7: assert property (@(posedge clk) disable iff (rst)
    (lk_en && lk_kind != 2'd2) |=> !res_ex);

  p_fault_blank_r8: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_cause != 4'd0) |-> (res_pa == '0 && !res_rd && !res_wr && !res_ex));

  p_pte_align_r9: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> res_pte_addr[1:0] == 2'b00);

  p_rr_step_r10: assert property (@(posedge clk) disable iff (rst)
    fill_en |=> fill_way_next == $past(fill_way_next) + 2'd1);
endmodule

// File: tb/tb_asid_tlb_xlate.sv
module tb_asid_tlb_xlate;
  logic        clk = 1'b0;
  logic        rst;
  logic        lk_en;
  logic [31:0] lk_va;
  logic [1:0]  lk_kind;
  logic [1:0]  lk_ring;
  logic [31:0] pt_base;
  logic        ring_we;
  logic [31:0] ring_wdata;
  logic        fill_en;
  logic [31:0] fill_va;
  logic [31:0] fill_pte;
  logic        res_valid;
  logic [31:0] res_pa;
  logic        res_rd, res_wr, res_ex;
  logic [1:0]  res_cache;
  logic [3:0]  res_cause;
  logic [31:0] res_pte_addr;
  logic [1:0]  fill_way_next;

  always #5 clk = ~clk;

  asid_tlb_xlate dut (
    .clk(clk), .rst(rst), .lk_en(lk_en), .lk_va(lk_va), .lk_kind(lk_kind),
    .lk_ring(lk_ring), .pt_base(pt_base), .ring_we(ring_we), .ring_wdata(ring_wdata),
    .fill_en(fill_en), .fill_va(fill_va), .fill_pte(fill_pte),
    .res_valid(res_valid), .res_pa(res_pa), .res_rd(res_rd), .res_wr(res_wr),
    .res_ex(res_ex), .res_cache(res_cache), .res_cause(res_cause),
    .res_pte_addr(res_pte_addr), .fill_way_next(fill_way_next)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // behavioural model: 4 ways x 4 sets
  int unsigned m_vpn  [4][4];
  int unsigned m_ppn  [4][4];
  int unsigned m_asid [4][4];
  int unsigned m_attr [4][4];
  int unsigned m_ring_word;
  int unsigned m_rr;

  // expected result
  int unsigned e_pa, e_cause, e_cache, e_pte;
  bit e_rd, e_wr, e_ex;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic model_lookup(input int unsigned va, input int kind, input int ring);
    int hits = 0;
    int unsigned h_ppn = 0, h_attr = 0, h_ring = 0;
    int unsigned vpn = va >> 12;
    int set = int'(vpn & 3);
    bit fetch = (kind == 2);
    bit store = (kind == 1);
    bit r = 0, w = 0, x = 0, ok;
    int unsigned c = 0;
    for (int wy = 0; wy < 4; wy++) begin
      int found = -1;
      for (int b = 3; b >= 0; b--)
        if (((m_ring_word >> (8*b)) & 32'hff) == m_asid[wy][set]) found = b;
      if (m_vpn[wy][set] == vpn && m_asid[wy][set] != 0 && found >= 0) begin
        hits++;
        h_ppn = m_ppn[wy][set]; h_attr = m_attr[wy][set]; h_ring = found;
      end
    end
    if (h_attr < 12) begin
      r = 1; x = h_attr[0]; w = h_attr[1]; c = (h_attr >> 2) & 3;
    end else if (h_attr == 13) begin
      r = 1; w = 1; c = 3;
    end
    if (fetch) begin r = 0; w = 0; end else x = 0;
    ok = fetch ? x : (store ? w : r);
    if (hits == 0)              e_cause = fetch ? 1 : 5;
    else if (hits > 1)          e_cause = fetch ? 2 : 6;
    else if (h_ring < ring)     e_cause = fetch ? 3 : 7;
    else if (!ok)               e_cause = fetch ? 4 : (store ? 9 : 8);
    else                        e_cause = 0;
    if (e_cause == 0) begin
      e_pa = (h_ppn << 12) | (va & 32'hfff);
      e_rd = r; e_wr = w; e_ex = x; e_cache = c;
    end else begin
      e_pa = 0; e_rd = 0; e_wr = 0; e_ex = 0; e_cache = 0;
    end
    e_pte = (pt_base | (va >> 10)) & 32'hffff_fffc;
  endtask

  function automatic string cause_req(input int unsigned c);
    case (c)
      1, 2, 5, 6: return "R3";
      3, 7:       return "R4";
      4, 8, 9:    return "R7";
      default:    return "R5";
    endcase
  endfunction

  // One cycle: drive at negedge, update model, compare at next negedge.
  task automatic step(input bit le, input int unsigned va, input int kind, input int ring,
                      input bit fe, input int unsigned fva, input int unsigned fpte,
                      input bit rwe, input int unsigned rwd);
    lk_en = le; lk_va = va; lk_kind = 2'(kind); lk_ring = 2'(ring);
    fill_en = fe; fill_va = fva; fill_pte = fpte;
    ring_we = rwe; ring_wdata = rwd;
    if (le) model_lookup(va, kind, ring);
    if (fe) begin
      int wy = int'((m_rr + 1) & 3);
      int set = int'((fva >> 12) & 3);
      m_vpn[wy][set]  = fva >> 12;
      m_ppn[wy][set]  = fpte >> 12;
      m_attr[wy][set] = fpte & 15;
      m_asid[wy][set] = (m_ring_word >> (8 * ((fpte >> 4) & 3))) & 32'hff;
      m_rr = (m_rr + 1) & 3;
    end
    if (rwe) m_ring_word = rwd;
    @(posedge clk);
    @(negedge clk);
    lk_en = 0; fill_en = 0; ring_we = 0;
    check(res_valid == le, "R11", "res_valid", res_valid, le);
    check(fill_way_next == 2'((m_rr + 1) & 3), "R10", "fill_way_next", fill_way_next, (m_rr + 1) & 3);
    if (le) begin
      check(res_cause == 4'(e_cause), cause_req(e_cause), "res_cause", res_cause, e_cause);
      check(res_pa == e_pa, "R8", "res_pa", res_pa, e_pa);
      check({res_rd, res_wr, res_ex} == {e_rd, e_wr, e_ex}, "R5", "rights rwx",
            {res_rd, res_wr, res_ex}, {e_rd, e_wr, e_ex});
      check(res_cache == 2'(e_cache), "R6", "res_cache", res_cache, e_cache);
      check(res_pte_addr == e_pte, "R9", "res_pte_addr", res_pte_addr, e_pte);
    end
  endtask

  task automatic look(input int unsigned va, input int kind, input int ring);
    step(1, va, kind, ring, 0, 0, 0, 0, 0);
  endtask

  task automatic fill(input int unsigned va, input int unsigned pte);
    step(0, 0, 0, 0, 1, va, pte, 0, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1; lk_en = 0; lk_va = 0; lk_kind = 0; lk_ring = 0;
    pt_base = 32'h8000_0000; ring_we = 0; ring_wdata = 0;
    fill_en = 0; fill_va = 0; fill_pte = 0;
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++) begin
        m_vpn[a][b] = 0; m_ppn[a][b] = 0; m_asid[a][b] = 0; m_attr[a][b] = 0;
      end
    m_ring_word = 32'h0403_0201; m_rr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // reset state (R1, R10, R11)
    check(res_valid == 0, "R11", "reset res_valid", res_valid, 0);
    check(fill_way_next == 2'd1, "R10", "reset fill_way_next", fill_way_next, 1);
    // R2: empty buffer misses everywhere, including page 0
    look(32'h0000_1234, 0, 0);
    look(32'h0000_0000, 2, 0);
    // R10: refill to way 1, ring 0 -> tag 0x01, attr 3 (rwx-ish, bypass)
    fill(32'h0000_1000, 32'h1234_5003);
    look(32'h0000_1abc, 0, 0);      // R8 address
    look(32'h0000_1abc, 1, 0);      // store allowed
    look(32'h0000_1abc, 2, 0);      // fetch allowed
    look(32'h0000_1abc, 0, 1);      // R4 data privilege
    look(32'h0000_1abc, 2, 3);      // R4 fetch privilege
    look(32'h1000_1abc, 0, 0);      // R2 tag mismatch in same set
    // ring 2, attr 5: write-back, read+exec
    fill(32'h0000_2000, 32'h0020_0025);
    look(32'h0000_2444, 0, 2);
    look(32'h0000_2444, 1, 2);      // R7 store prohibited
    look(32'h0000_2444, 2, 1);
    // ring 1, attr 8: write-through, read only
    fill(32'h0000_3000, 32'h0030_0018);
    look(32'h0000_3010, 2, 0);      // R7 fetch prohibited
    look(32'h0000_3010, 3, 1);      // kind 3 acts as load
    // ring 3, attr 13: isolate (R6)
    fill(32'h0000_4000, 32'h0040_003d);
    look(32'h0000_4ffc, 0, 3);
    look(32'h0000_4ffc, 1, 2);
    look(32'h0000_4ffc, 2, 0);
    // attr 12 and 15 grant nothing (R6), overwrites way 1 set 1
    fill(32'h0000_5000, 32'h0050_000c);
    look(32'h0000_5000, 0, 0);
    fill(32'h0000_9000, 32'h0090_000f);
    look(32'h0000_9000, 1, 0);
    // R3 multi-hit: same page in two ways
    fill(32'h0000_6000, 32'h0060_0007);
    fill(32'h0000_6000, 32'h0061_0007);
    look(32'h0000_6100, 0, 0);
    look(32'h0000_6100, 2, 0);
    // R11: multi-hit outranks privilege
    look(32'h0000_6100, 0, 3);
    // R1: rewrite ring word, tag 0x01 no longer present
    step(0, 0, 0, 0, 0, 0, 0, 1, 32'h0403_0209);
    look(32'h0000_9000, 0, 0);
    fill(32'h0000_7000, 32'h0070_0007);  // ring 0 -> tag 0x09
    look(32'h0000_7008, 1, 0);
    // R1: duplicate byte values, lowest index gives ring
    step(0, 0, 0, 0, 0, 0, 0, 1, 32'h0903_0209);
    look(32'h0000_7008, 0, 1);
    // R11: refill and lookup in the same cycle see old contents
    step(1, 32'h0000_8000, 0, 0, 1, 32'h0000_8000, 32'h0080_0007, 0, 0);
    look(32'h0000_8000, 0, 0);
    // R9 with a different page-table base
    pt_base = 32'h00c0_0000;
    look(32'hffff_f123, 2, 0);
    // idle cycle: no stray result
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule